// File: doc/BRIEF.md
# Decimal Adjust Accumulator Unit

This block corrects the result of a byte-wide binary add or subtract so that it reads as decimal digits again. It also converts between a byte and two unpacked decimal digits. It works on an 8-bit low accumulator byte and a companion high byte. A 3-bit operation code chooses one of six corrections:

- packed add and packed subtract, with two digits held in one byte;
- unpacked add and unpacked subtract, with one digit per byte;
- split-into-digits, which divides the low byte by a base;
- join-digits, which multiplies the high byte by a base and adds the low byte.

The last two use an immediate base input.

The block takes the incoming carry and auxiliary-carry flags. It returns the new pair of bytes with carry, auxiliary-carry, zero, parity and sign flags. A split with a base of zero raises a divide-fault output. The surrounding pipeline keeps the flag register and delivers faults.

The correction logic is purely combinational. Every result is computed into a single next-state record and registered once, so outputs follow the inputs by one clock.

Top module: `dadj_unit`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: The inputs present at a rising clock edge determine the outputs seen after that edge. A new operation can be applied on every cycle.
- R3: Packed add (op 0) works in two steps:
  - Step one: if the low nibble of `lo_i` is above 9 or `af_i` is 1, add 6 to the byte, and `af_o` is 1; otherwise `af_o` is 0.
  - Step two: if the original `lo_i` is above 0x99 or `cf_i` is 1, add 0x60 to the result of step one, and `cf_o` is 1; otherwise `cf_o` is 0.
  - Both sums wrap modulo 256.
- R4: Packed subtract (op 1) works in two steps:
  - Step one: if the low nibble is above 9 or `af_i` is 1, subtract 6 and `af_o` is 1. In that case `cf_o` is also 1 when the original byte is below 6 or `cf_i` is 1.
  - Step two: if the original byte is above 0x99 or `cf_i` is 1, subtract 0x60 from the result of step one, and `cf_o` is 1.
  - Both differences wrap modulo 256.
- R5: For every operation, three flags are computed from the registered low result:
  - `zf_o` is 1 when the low result is 0;
  - `pf_o` is 1 when the low result has an even number of one bits;
  - `sf_o` is bit 7 of the low result.
- R6: Unpacked add (op 2) depends on whether the low nibble is above 9 or `af_i` is 1:
  - If so, `lo_o` is (`lo_i`+6) mod 16, and `hi_o` is `hi_i`+1 mod 256, plus a further 1 when `lo_i` is above 0xF9. Carry and auxiliary carry are both 1.
  - Otherwise, `lo_o` is the low nibble of `lo_i`, `hi_o` equals `hi_i`, and both flags are 0.
- R7: Unpacked subtract (op 3) has the same condition as R6:
  - If it holds, `lo_o` is (`lo_i`-6) mod 16, and `hi_o` is `hi_i`-1 mod 256, less a further 1 when `lo_i` is below 6. Carry and auxiliary carry are both 1.
  - Otherwise, it behaves as in R6.
- R8: The packed operations (op 0, 1) return `hi_i` unchanged on `hi_o`. The unpacked operations always give `cf_o` equal to `af_o`.
- R9: Split-into-digits (op 4) with a nonzero `base_i` gives `hi_o` = `lo_i` / `base_i` and `lo_o` = `lo_i` mod `base_i`.
- R10: Join-digits (op 5) gives `lo_o` = (`hi_i`*`base_i` + `lo_i`) mod 256 and `hi_o` = 0. A zero base is legal here.
- R11: Split-into-digits with `base_i` = 0 sets `div_fault_o` and returns `lo_i` and `hi_i` unchanged. `div_fault_o` is 0 for every other case.
- R12: Split and join (op 4, 5) drive `cf_o` and `af_o` to 0.
- R13: The reserved codes 6 and 7 return both bytes unchanged and pass `cf_i` and `af_i` through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 to 5 used, 6 and 7 reserved) |
| lo_i | input | 8 | Low accumulator byte |
| hi_i | input | 8 | High companion byte |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary-carry flag |
| base_i | input | 8 | Immediate base for split and join |
| lo_o | output | 8 | Adjusted low byte |
| hi_o | output | 8 | Adjusted high byte |
| cf_o | output | 1 | Carry out |
| af_o | output | 1 | Auxiliary carry out |
| zf_o | output | 1 | Zero flag of the low result |
| pf_o | output | 1 | Even-parity flag of the low result |
| sf_o | output | 1 | Sign flag of the low result |
| div_fault_o | output | 1 | Split attempted with base zero |

## Verification
The unit has no tunable parameters; the 8-bit byte width is fixed by the decimal correction constants. The bench therefore builds the single default configuration.

Because the input space per operation is small, the bench sweeps every low byte against all four carry and auxiliary-carry combinations for the four adjust codes. This reaches every boundary of the nibble-above-9, above-0x99, below-6 and above-0xF9 conditions.

The bench also sweeps every low byte through the split against a set of bases that includes 0, 1 and 255. It runs join-digits with wrapping products and exercises both reserved codes.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PADD  = 3'd0,
        OP_PSUB  = 3'd1,
        OP_UADD  = 3'd2,
        OP_USUB  = 3'd3,
        OP_SPLIT = 3'd4,
        OP_JOIN  = 3'd5
    } dadj_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              cf;
        logic              af;
        logic              zf;
        logic              pf;
        logic              sf;
        logic              fault;
    } dadj_res_t;

endpackage

// File: rtl/dadj_packed.sv
module dadj_packed
    import dadj_pkg::*;
(
    input  logic              sub_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic              cf_i,
    input  logic              af_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic              cf_o,
    output logic              af_o
);
    localparam logic [BYTE_W-1:0] LOW_FIX  = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] HIGH_FIX = BYTE_W'(8'h60);
    localparam logic [BYTE_W-1:0] HIGH_LIM = BYTE_W'(8'h99);
    localparam logic [NIB_W-1:0]  NIB_LIM  = NIB_W'(9);

    logic              low_fix;
    logic              high_fix;
    logic [BYTE_W-1:0] step1;

    always_comb begin
        low_fix  = (lo_i[NIB_W-1:0] > NIB_LIM) || af_i;
        high_fix = (lo_i > HIGH_LIM) || cf_i;
        if (low_fix) begin
            step1 = sub_i ? (lo_i - LOW_FIX) : (lo_i + LOW_FIX);
        end else begin
            step1 = lo_i;
        end
        if (high_fix) begin
            lo_o = sub_i ? (step1 - HIGH_FIX) : (step1 + HIGH_FIX);
        end else begin
            lo_o = step1;
        end
        af_o = low_fix;
        // a subtract whose low step borrows past zero also borrows out
        cf_o = high_fix || (sub_i && low_fix && (lo_i < LOW_FIX));
    end
endmodule

// File: rtl/dadj_unpacked.sv
module dadj_unpacked
    import dadj_pkg::*;
(
    input  logic              sub_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              af_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              adj_o
);
    localparam logic [BYTE_W-1:0] LOW_FIX = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] WRAP_UP = BYTE_W'(8'hF9);
    localparam logic [NIB_W-1:0]  NIB_LIM = NIB_W'(9);

    logic              adj;
    logic              extra;
    logic [BYTE_W-1:0] lo_fix;

    always_comb begin
        adj    = (lo_i[NIB_W-1:0] > NIB_LIM) || af_i;
        extra  = sub_i ? (lo_i < LOW_FIX) : (lo_i > WRAP_UP);
        lo_fix = sub_i ? (lo_i - LOW_FIX) : (lo_i + LOW_FIX);
        if (adj) begin
            lo_o = {{(BYTE_W-NIB_W){1'b0}}, lo_fix[NIB_W-1:0]};
            if (sub_i) begin
                hi_o = hi_i - BYTE_W'(1) - {{(BYTE_W-1){1'b0}}, extra};
            end else begin
                hi_o = hi_i + BYTE_W'(1) + {{(BYTE_W-1){1'b0}}, extra};
            end
        end else begin
            lo_o = {{(BYTE_W-NIB_W){1'b0}}, lo_i[NIB_W-1:0]};
            hi_o = hi_i;
        end
        adj_o = adj;
    end
endmodule

// File: rtl/dadj_base.sv
module dadj_base
    import dadj_pkg::*;
(
    input  logic              join_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] base_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              fault_o
);
    logic              zero_base;
    logic [BYTE_W-1:0] divisor;
    logic [BYTE_W-1:0] quot;
    logic [BYTE_W-1:0] rem;
    logic [BYTE_W-1:0] joined;

    always_comb begin
        zero_base = (base_i == '0);
        // a safe divisor keeps the divider defined; the result is discarded on fault
        divisor   = zero_base ? BYTE_W'(1) : base_i;
        quot      = lo_i / divisor;
        rem       = lo_i % divisor;
        joined    = hi_i * base_i + lo_i;
        if (join_i) begin
            lo_o    = joined;
            hi_o    = '0;
            fault_o = 1'b0;
        end else if (zero_base) begin
            lo_o    = lo_i;
            hi_o    = hi_i;
            fault_o = 1'b1;
        end else begin
            lo_o    = rem;
            hi_o    = quot;
            fault_o = 1'b0;
        end
    end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
    import dadj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              cf_i,
    input  logic              af_i,
    input  logic [BYTE_W-1:0] base_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              cf_o,
    output logic              af_o,
    output logic              zf_o,
    output logic              pf_o,
    output logic              sf_o,
    output logic              div_fault_o
);
    logic [BYTE_W-1:0] pk_lo;
    logic              pk_cf;
    logic              pk_af;
    logic [BYTE_W-1:0] up_lo;
    logic [BYTE_W-1:0] up_hi;
    logic              up_adj;
    logic [BYTE_W-1:0] bs_lo;
    logic [BYTE_W-1:0] bs_hi;
    logic              bs_fault;

    dadj_res_t res_d;
    dadj_res_t res_q;

    dadj_packed u_packed (
        .sub_i (op_i == OP_PSUB),
        .lo_i  (lo_i),
        .cf_i  (cf_i),
        .af_i  (af_i),
        .lo_o  (pk_lo),
        .cf_o  (pk_cf),
        .af_o  (pk_af)
    );

    dadj_unpacked u_unpacked (
        .sub_i (op_i == OP_USUB),
        .lo_i  (lo_i),
        .hi_i  (hi_i),
        .af_i  (af_i),
        .lo_o  (up_lo),
        .hi_o  (up_hi),
        .adj_o (up_adj)
    );

    dadj_base u_base (
        .join_i  (op_i == OP_JOIN),
        .lo_i    (lo_i),
        .hi_i    (hi_i),
        .base_i  (base_i),
        .lo_o    (bs_lo),
        .hi_o    (bs_hi),
        .fault_o (bs_fault)
    );

    always_comb begin
        res_d       = '0;
        res_d.lo    = lo_i;
        res_d.hi    = hi_i;
        res_d.cf    = cf_i;
        res_d.af    = af_i;
        case (op_i)
            OP_PADD, OP_PSUB: begin
                res_d.lo = pk_lo;
                res_d.cf = pk_cf;
                res_d.af = pk_af;
            end
            OP_UADD, OP_USUB: begin
                res_d.lo = up_lo;
                res_d.hi = up_hi;
                res_d.cf = up_adj;
                res_d.af = up_adj;
            end
            OP_SPLIT: begin
                res_d.lo    = bs_lo;
                res_d.hi    = bs_hi;
                res_d.cf    = 1'b0;
                res_d.af    = 1'b0;
                res_d.fault = bs_fault;
            end
            OP_JOIN: begin
                res_d.lo = bs_lo;
                res_d.hi = bs_hi;
                res_d.cf = 1'b0;
                res_d.af = 1'b0;
            end
            default: ;
        endcase
        res_d.zf = (res_d.lo == '0);
        res_d.pf = ~^res_d.lo;
        res_d.sf = res_d.lo[BYTE_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign lo_o        = res_q.lo;
    assign hi_o        = res_q.hi;
    assign cf_o        = res_q.cf;
    assign af_o        = res_q.af;
    assign zf_o        = res_q.zf;
    assign pf_o        = res_q.pf;
    assign sf_o        = res_q.sf;
    assign div_fault_o = res_q.fault;

    // R11
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_fault_o |-> ($past(op_i) == OP_SPLIT) && ($past(base_i) == '0));

    // R6
    unpacked_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(op_i) == OP_UADD) || ($past(op_i) == OP_USUB)))
        |-> (lo_o[BYTE_W-1:NIB_W] == '0));

    // R8
    unpacked_flags_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(op_i) == OP_UADD) || ($past(op_i) == OP_USUB)))
        |-> (cf_o == af_o));

    // R8
    packed_high_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(op_i) == OP_PADD) || ($past(op_i) == OP_PSUB)))
        |-> (hi_o == $past(hi_i)));

    // R10
    join_high_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == OP_JOIN)) |-> (hi_o == '0));

    // R5
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pf_o == ~^lo_o));

    // R12
    base_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(op_i) == OP_SPLIT) || ($past(op_i) == OP_JOIN)))
        |-> (!cf_o && !af_o));
endmodule

// File: tb/tb_dadj_unit.sv
module tb_dadj_unit;
    logic       clk;
    logic       rst_n;
    logic [2:0] op_i;
    logic [7:0] lo_i, hi_i, base_i;
    logic       cf_i, af_i;
    logic [7:0] lo_o, hi_o;
    logic       cf_o, af_o, zf_o, pf_o, sf_o, div_fault_o;

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        logic       cf;
        logic       af;
        logic       zf;
        logic       pf;
        logic       sf;
        logic       ft;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;

    dadj_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .lo_i(lo_i), .hi_i(hi_i),
        .cf_i(cf_i), .af_i(af_i), .base_i(base_i), .lo_o(lo_o), .hi_o(hi_o),
        .cf_o(cf_o), .af_o(af_o), .zf_o(zf_o), .pf_o(pf_o), .sf_o(sf_o),
        .div_fault_o(div_fault_o)
    );

    initial clk = 0;
    always #4 clk = ~clk;

    function automatic exp_t model(int op, int l, int h, int c, int a, int b);
        exp_t e;
        int   nl, nh, nc, na, nf;
        bit   low_cond;
        nl = l; nh = h; nc = c; na = a; nf = 0;
        low_cond = ((l % 16) > 9) || (a != 0);
        case (op)
            0: begin
                na = low_cond;
                if (low_cond) nl = (l + 6) % 256;
                nc = 0;
                if (l > 153 || c != 0) begin nl = (nl + 96) % 256; nc = 1; end
            end
            1: begin
                na = low_cond;
                nc = 0;
                if (low_cond) begin
                    if (l < 6 || c != 0) nc = 1;
                    nl = (l + 250) % 256;
                end
                if (l > 153 || c != 0) begin nl = (nl + 160) % 256; nc = 1; end
            end
            2, 3: begin
                if (low_cond) begin
                    if (op == 2) begin
                        nl = (l + 6) % 16;
                        nh = (h + 1 + ((l > 249) ? 1 : 0)) % 256;
                    end else begin
                        nl = (l + 250) % 16;
                        nh = (h + 512 - 1 - ((l < 6) ? 1 : 0)) % 256;
                    end
                    nc = 1; na = 1;
                end else begin
                    nl = l % 16; nc = 0; na = 0;
                end
            end
            4: begin
                nc = 0; na = 0;
                if (b == 0) nf = 1;
                else begin nh = l / b; nl = l % b; end
            end
            5: begin
                nc = 0; na = 0;
                nl = (h * b + l) % 256; nh = 0;
            end
            default: ;
        endcase
        e.lo = 8'(nl); e.hi = 8'(nh); e.cf = nc[0]; e.af = na[0];
        e.zf = (nl == 0); e.pf = ~^e.lo; e.sf = e.lo[7]; e.ft = nf[0];
        return e;
    endfunction

    task automatic apply(int op, int l, int h, int c, int a, int b, string tag);
        @(negedge clk);
        op_i = 3'(op); lo_i = 8'(l); hi_i = 8'(h);
        cf_i = c[0]; af_i = a[0]; base_i = 8'(b);
        expq.push_back(model(op, l, h, c, a, b));
        tagq.push_back(tag);
    endtask

    // monitor: result of inputs applied at a negedge is visible after the next posedge
    always begin
        @(posedge clk);
        #2;
        if (rst_n && expq.size() > 0) begin
            exp_t  e;
            exp_t  g;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            g = {lo_o, hi_o, cf_o, af_o, zf_o, pf_o, sf_o, div_fault_o};
            n_vec++;
            if (g !== e) begin
                n_bad++;
                $display("FAIL %s: got lo=%h hi=%h cf=%b af=%b zf=%b pf=%b sf=%b ft=%b, expected lo=%h hi=%h cf=%b af=%b zf=%b pf=%b sf=%b ft=%b",
                         t, g.lo, g.hi, g.cf, g.af, g.zf, g.pf, g.sf, g.ft,
                         e.lo, e.hi, e.cf, e.af, e.zf, e.pf, e.sf, e.ft);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; op_i = 3'd0; lo_i = 8'h9A; hi_i = 8'h55;
        cf_i = 1; af_i = 1; base_i = 8'd10;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        n_vec++;
        if ({lo_o, hi_o, cf_o, af_o, zf_o, pf_o, sf_o, div_fault_o} !== 24'h0) begin
            n_bad++;
            $display("FAIL R1: got %h, expected 0",
                     {lo_o, hi_o, cf_o, af_o, zf_o, pf_o, sf_o, div_fault_o});
        end
        @(negedge clk);
        rst_n = 1;

        // R2: back-to-back operations of different kinds
        apply(0, 8'h9A, 8'h11, 0, 0, 10, "R2");
        apply(4, 8'd99, 8'h00, 0, 0, 10, "R2");
        apply(5, 8'd7,  8'd9,  1, 1, 10, "R2");
        apply(3, 8'h00, 8'h00, 0, 1, 10, "R2");

        for (int l = 0; l < 256; l++)
            for (int f = 0; f < 4; f++) begin
                apply(0, l, l ^ 8'h3C, f & 1, f >> 1, 0, "R3,R5,R8");
                apply(1, l, ~l & 8'hFF, f & 1, f >> 1, 0, "R4,R5,R8");
            end

        for (int l = 0; l < 256; l++)
            for (int f = 0; f < 4; f++) begin
                apply(2, l, (f == 3) ? 8'hFF : (l ^ 8'hA5), f & 1, f >> 1, 0, "R6,R8");
                apply(3, l, (f == 3) ? 8'h00 : (l ^ 8'h5A), f & 1, f >> 1, 0, "R7,R8");
            end

        for (int l = 0; l < 256; l++) begin
            apply(4, l, 8'hC3, 1, 1, 10,  "R9,R12");
            apply(4, l, 8'h3C, 0, 1, 1,   "R9,R12");
            apply(4, l, 8'h00, 1, 0, 7,   "R9");
            apply(4, l, 8'h77, 0, 0, 16,  "R9");
            apply(4, l, 8'h01, 1, 0, 255, "R9");
            apply(4, l, l ^ 8'h81, 1, 1, 0, "R11,R12");
        end

        for (int h = 0; h < 256; h += 5)
            for (int b = 0; b < 256; b += 51) begin
                apply(5, (h * 3) & 8'hFF, h, 1, 1, b, "R10,R12");
            end
        apply(5, 8'd9, 8'd9, 0, 0, 10, "R10");
        apply(5, 8'hFF, 8'hFF, 0, 0, 255, "R10");

        for (int l = 0; l < 256; l += 17)
            for (int f = 0; f < 4; f++) begin
                apply(6, l, l ^ 8'hF0, f & 1, f >> 1, 0, "R13");
                apply(7, l, 8'hE7, f & 1, f >> 1, 0, "R13");
            end

        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule